// File: doc/BRIEF.md
# Dual-Bank Register File with Exchange

This block is the working register storage of an 8/16/32-bit processor core. It keeps two copies, a primary and an alternate, of the three general pairs BC, DE and HL and of the two index registers IX and IY. It also holds a single 8-bit accumulator A. The byte registers B, C, D, E, H and L are the upper and lower bytes of the low 16 bits of the pairs. Three bank-select flags in a 32-bit status word choose independently which copy is active for the pair group, for IX and for IY. Every read and write port sees only the active copy of each register.

A decoded operation code, applied for one clock, performs one action per cycle. It can exchange two word registers, or a word register with the inactive copy of another. It can exchange A with a byte register, or a byte register with its alternate copy. It can rotate the 16-bit halves of a word register, or invert one or all of the bank-select flags. Word transfers honour a word-length input: 16-bit mode moves only bits 15..0, and 32-bit mode moves the whole word. The half rotation does not depend on that input. Switching a bank changes which copy is seen and moves no data, so software can tell the banks apart by reading the status word.

Top module: `dual_bank_rf`

## Requirements
- R1: On a synchronous reset every register copy, A, both read outputs and the status word are 0, so the primary copies are active.
- R2: The read outputs are registered. `rd_word` shows the active copy of the register coded by `rd_wsel` (0 BC, 1 DE, 2 HL, 3 IX, 4 IY) one clock after the select, and codes 5 to 7 read 0. `rd_byte` shows the byte coded by `rd_bsel` (0 A, 1 B, 2 C, 3 D, 4 E, 5 H, 6 L), where B, D and H are bits 15..8 and C, E and L are bits 7..0 of the active BC, DE and HL. Code 7 reads 0.
- R3: A word write with `op` = 0 updates the active copy of `wr_sel`. In 32-bit mode (`long_mode` = 1) it writes all bits. In 16-bit mode it writes bits 15..0 and keeps bits 31..16. Writes of either kind have no effect while `op` is nonzero.
- R4: A byte write with `op` = 0 updates A or the addressed byte of the active pair. When it targets a byte of the same pair as a word write in the same cycle, the byte write takes precedence.
- R5: `op` = 1 exchanges the active copies of registers `op_a` and `op_b`, using bits 15..0 in 16-bit mode and all 32 bits in 32-bit mode. Both results take the values from before the edge.
- R6: `op` = 2 exchanges the active copy of `op_a` with the inactive copy of `op_b`, with the same width rule as R5. This covers a pair with its own alternate copy and a pair with an alternate index copy.
- R7: `op` = 3 exchanges A with the byte register coded by `op_b` (codes 1 to 6).
- R8: `op` = 4 exchanges the byte coded by `op_a` (codes 1 to 6) between the primary and alternate copies of its pair. The other byte of that pair is not touched.
- R9: `op` = 5 exchanges bits 31..16 with bits 15..0 of the active copy of `op_a`, in either word-length mode.
- R10: `op` = 6 inverts status bits 8, 16 and 24. Bit 8 selects the bank of BC/DE/HL, bit 16 the bank of IX and bit 24 the bank of IY.
- R11: `op` = 7 inverts only status bit 16 and `op` = 8 inverts only bit 24. No other operation changes the status word.
- R12: All status bits other than 8, 16 and 24 read 0. Operation codes 9 to 15 and out-of-range register codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | 1 selects 32-bit transfers, 0 selects 16-bit |
| op | input | 4 | Operation code for this cycle, 0 for none |
| op_a | input | 3 | First operand register code |
| op_b | input | 3 | Second operand register code |
| wr_en | input | 1 | Word write enable |
| wr_sel | input | 3 | Word register code to write |
| wr_data | input | WORD_W | Word write data |
| bwr_en | input | 1 | Byte write enable |
| bwr_sel | input | 3 | Byte register code to write |
| bwr_data | input | 8 | Byte write data |
| rd_wsel | input | 3 | Word register code to read |
| rd_bsel | input | 3 | Byte register code to read |
| rd_word | output | WORD_W | Registered word read data |
| rd_byte | output | 8 | Registered byte read data |
| status | output | 32 | Bank-select status word |

## Verification
The inactive copies are the hardest state to observe, because no port reads them directly. A cross-bank exchange or a byte exchange with the alternate copy therefore shows up only after a later bank flip brings that copy into view. The stimulus first loads distinct values into both banks by writing, flipping all selects and writing again. It then runs cross exchanges and flips single groups, so that IX, IY and the pairs sit in mixed bank states before they are read back. A 16-bit exchange must keep the upper halves, so 32-bit values are loaded first to make a damaged upper half visible.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NWREG   = 5;
  localparam int SEL_W   = 3;
  localparam int STAT_W  = 32;
  localparam int SB_PAIR = 8;
  localparam int SB_IX   = 16;
  localparam int SB_IY   = 24;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_XCHG      = 4'd1,
    OP_XALT      = 4'd2,
    OP_XBYTE_A   = 4'd3,
    OP_XBYTE_ALT = 4'd4,
    OP_HSWAP     = 4'd5,
    OP_FLIP_ALL  = 4'd6,
    OP_FLIP_IX   = 4'd7,
    OP_FLIP_IY   = 4'd8
  } rf_op_e;

  function automatic logic [3:0] slot(input logic [SEL_W-1:0] r, input logic bk);
    return {r, bk};
  endfunction

  function automatic logic byte_code_ok(input logic [SEL_W-1:0] c);
    return (c >= 3'd1) && (c <= 3'd6);
  endfunction

  function automatic logic [SEL_W-1:0] byte_pair(input logic [SEL_W-1:0] c);
    return (c - 3'd1) >> 1;
  endfunction
endpackage

// File: rtl/rf_bank_sel.sv
module rf_bank_sel
  import rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           op,
  output logic [STAT_W-1:0]    status,
  output logic [NWREG-1:0]     bank_sel
);
  // flags[0] pairs, flags[1] IX, flags[2] IY
  logic [2:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      case (rf_op_e'(op))
        OP_FLIP_ALL: flags <= flags ^ 3'b111;
        OP_FLIP_IX:  flags <= flags ^ 3'b010;
        OP_FLIP_IY:  flags <= flags ^ 3'b100;
        default:     flags <= flags;
      endcase
    end
  end

  always_comb begin
    status          = '0;
    status[SB_PAIR] = flags[0];
    status[SB_IX]   = flags[1];
    status[SB_IY]   = flags[2];
  end

  for (genvar r = 0; r < NWREG; r++) begin : g_sel
    if (r < 3) begin : g_pair
      assign bank_sel[r] = flags[0];
    end else if (r == 3) begin : g_ix
      assign bank_sel[r] = flags[1];
    end else begin : g_iy
      assign bank_sel[r] = flags[2];
    end
  end
endmodule

// File: rtl/rf_word_file.sv
module rf_word_file
  import rf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [3:0]                      op,
  input  logic                            long_mode,
  input  logic [SEL_W-1:0]                op_a,
  input  logic [SEL_W-1:0]                op_b,
  input  logic [NWREG-1:0]                bank_sel,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [WORD_W-1:0]               wr_data,
  input  logic                            bwr_en,
  input  logic [SEL_W-1:0]                bwr_sel,
  input  logic [7:0]                      bwr_data,
  output logic [NWREG-1:0][WORD_W-1:0]    act_word,
  output logic [7:0]                      acc
);
  localparam int HALF  = WORD_W / 2;
  localparam int SLOTS = 2 * NWREG;

  logic [WORD_W-1:0] mem_q [SLOTS];
  logic [WORD_W-1:0] mem_d [SLOTS];
  logic [7:0]        acc_q, acc_d;
  logic [7:0]        bsel_pad;

  assign bsel_pad = 8'(bank_sel);

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] dst,
                                              input logic [WORD_W-1:0] src,
                                              input logic lng);
    return lng ? src : {dst[WORD_W-1:HALF], src[HALF-1:0]};
  endfunction

  function automatic logic [7:0] get_b(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [WORD_W-1:0] put_b(input logic [WORD_W-1:0] w,
                                              input logic hi, input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  always_comb begin
    logic [3:0]       ia, ib;
    logic [SEL_W-1:0] p;
    logic [7:0]       t;
    mem_d = mem_q;
    acc_d = acc_q;
    ia = '0;
    ib = '0;
    p  = '0;
    t  = '0;
    case (rf_op_e'(op))
      OP_XCHG, OP_XALT: begin
        if (op_a < SEL_W'(NWREG) && op_b < SEL_W'(NWREG)) begin
          ia = slot(op_a, bsel_pad[op_a]);
          ib = (rf_op_e'(op) == OP_XALT) ? slot(op_b, ~bsel_pad[op_b])
                                         : slot(op_b, bsel_pad[op_b]);
          mem_d[ia] = merge(mem_q[ia], mem_q[ib], long_mode);
          mem_d[ib] = merge(mem_q[ib], mem_q[ia], long_mode);
        end
      end
      OP_HSWAP: begin
        if (op_a < SEL_W'(NWREG)) begin
          ia = slot(op_a, bsel_pad[op_a]);
          mem_d[ia] = {mem_q[ia][HALF-1:0], mem_q[ia][WORD_W-1:HALF]};
        end
      end
      OP_XBYTE_A: begin
        if (byte_code_ok(op_b)) begin
          p  = byte_pair(op_b);
          ia = slot(p, bsel_pad[p]);
          acc_d = get_b(mem_q[ia], op_b[0]);
          mem_d[ia] = put_b(mem_q[ia], op_b[0], acc_q);
        end
      end
      OP_XBYTE_ALT: begin
        if (byte_code_ok(op_a)) begin
          p  = byte_pair(op_a);
          ia = slot(p, 1'b0);
          ib = slot(p, 1'b1);
          t  = get_b(mem_q[ia], op_a[0]);
          mem_d[ia] = put_b(mem_q[ia], op_a[0], get_b(mem_q[ib], op_a[0]));
          mem_d[ib] = put_b(mem_q[ib], op_a[0], t);
        end
      end
      OP_NONE: begin
        if (wr_en && wr_sel < SEL_W'(NWREG)) begin
          ia = slot(wr_sel, bsel_pad[wr_sel]);
          mem_d[ia] = merge(mem_q[ia], wr_data, long_mode);
        end
        if (bwr_en) begin
          if (bwr_sel == '0) begin
            acc_d = bwr_data;
          end else if (byte_code_ok(bwr_sel)) begin
            p  = byte_pair(bwr_sel);
            ib = slot(p, bsel_pad[p]);
            mem_d[ib] = put_b(mem_d[ib], bwr_sel[0], bwr_data);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
      acc_q <= '0;
    end else begin
      mem_q <= mem_d;
      acc_q <= acc_d;
    end
  end

  for (genvar r = 0; r < NWREG; r++) begin : g_act
    assign act_word[r] = mem_q[2*r + int'(bank_sel[r])];
  end
  assign acc = acc_q;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NWREG-1:0][WORD_W-1:0] act_word,
  input  logic [7:0]                   acc,
  input  logic [SEL_W-1:0]             rd_wsel,
  input  logic [SEL_W-1:0]             rd_bsel,
  output logic [WORD_W-1:0]            rd_word,
  output logic [7:0]                   rd_byte
);
  logic [7:0][WORD_W-1:0] pad;
  logic [SEL_W-1:0]       bp;
  logic [7:0]             bnext;

  always_comb begin
    pad = '0;
    for (int r = 0; r < NWREG; r++) pad[r] = act_word[r];
  end

  always_comb begin
    bp = byte_pair(rd_bsel);
    if (rd_bsel == '0)              bnext = acc;
    else if (byte_code_ok(rd_bsel)) bnext = rd_bsel[0] ? pad[bp][15:8] : pad[bp][7:0];
    else                            bnext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
      rd_byte <= '0;
    end else begin
      rd_word <= pad[rd_wsel];
      rd_byte <= bnext;
    end
  end
endmodule

// File: rtl/dual_bank_rf.sv
module dual_bank_rf
  import rf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic [3:0]        op,
  input  logic [2:0]        op_a,
  input  logic [2:0]        op_b,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              bwr_en,
  input  logic [2:0]        bwr_sel,
  input  logic [7:0]        bwr_data,
  input  logic [2:0]        rd_wsel,
  input  logic [2:0]        rd_bsel,
  output logic [WORD_W-1:0] rd_word,
  output logic [7:0]        rd_byte,
  output logic [31:0]       status
);
  logic [NWREG-1:0]             bank_sel;
  logic [NWREG-1:0][WORD_W-1:0] act_word;
  logic [7:0]                   acc;

  rf_bank_sel u_bank (
    .clk(clk), .rst(rst), .op(op), .status(status), .bank_sel(bank_sel)
  );

  rf_word_file #(.WORD_W(WORD_W)) u_file (
    .clk(clk), .rst(rst), .op(op), .long_mode(long_mode),
    .op_a(op_a), .op_b(op_b), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bwr_en(bwr_en), .bwr_sel(bwr_sel), .bwr_data(bwr_data),
    .act_word(act_word), .acc(acc)
  );

  rf_read_port #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .act_word(act_word), .acc(acc),
    .rd_wsel(rd_wsel), .rd_bsel(rd_bsel),
    .rd_word(rd_word), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/dual_bank_rf_chk.sv
module dual_bank_rf_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op,
  input logic [31:0] status
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (status == 32'h0);
    end
  end

  assert_flip_all_R10: assert property (@(posedge clk) disable iff (rst)
    op == 4'd6 |=> status == ($past(status) ^ 32'h0101_0100));

  assert_flip_ix_R11: assert property (@(posedge clk) disable iff (rst)
    op == 4'd7 |=> status == ($past(status) ^ 32'h0001_0000));

  assert_flip_iy_R11: assert property (@(posedge clk) disable iff (rst)
    op == 4'd8 |=> status == ($past(status) ^ 32'h0100_0000));

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(op inside {4'd6, 4'd7, 4'd8}) |=> $stable(status));

  assert_spare_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (status & ~32'h0101_0100) == 32'h0);
endmodule

bind dual_bank_rf dual_bank_rf_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .status(status)
);

// File: tb/tb_dual_bank_rf.sv
`timescale 1ns/1ps
module tb_dual_bank_rf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        long_mode = 1'b1;
  logic [3:0]  op = '0;
  logic [2:0]  op_a = '0, op_b = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        bwr_en = 1'b0;
  logic [2:0]  bwr_sel = '0;
  logic [7:0]  bwr_data = '0;
  logic [2:0]  rd_wsel = '0, rd_bsel = '0;
  logic [31:0] rd_word;
  logic [7:0]  rd_byte;
  logic [31:0] status;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_bank_rf dut (
    .clk(clk), .rst(rst), .long_mode(long_mode), .op(op), .op_a(op_a), .op_b(op_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bwr_en(bwr_en), .bwr_sel(bwr_sel), .bwr_data(bwr_data),
    .rd_wsel(rd_wsel), .rd_bsel(rd_bsel),
    .rd_word(rd_word), .rd_byte(rd_byte), .status(status)
  );

  // reference model: m[bank][reg], reg 0 BC,1 DE,2 HL,3 IX,4 IY
  logic [31:0] m [0:1][0:4];
  logic [7:0]  ma;
  logic        f_pr, f_ix, f_iy;

  function automatic int bk(input int r);
    if (r < 3) return int'(f_pr);
    if (r == 3) return int'(f_ix);
    return int'(f_iy);
  endfunction

  function automatic logic [31:0] mg(input logic [31:0] d, input logic [31:0] s);
    return long_mode ? s : {d[31:16], s[15:0]};
  endfunction

  function automatic logic [7:0] rbyte(input int c);
    int p;
    if (c == 0) return ma;
    if (c > 6) return 8'h00;
    p = (c - 1) / 2;
    return (c % 2) ? m[bk(p)][p][15:8] : m[bk(p)][p][7:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick(input string req);
    logic [31:0] ew, es, va, vb;
    logic [7:0]  eb, t;
    int a, b, ba, bb, p;
    logic hi;
    a = int'(op_a);
    b = int'(op_b);
    ew = (rd_wsel < 5) ? m[bk(int'(rd_wsel))][rd_wsel] : 32'h0;
    eb = rbyte(int'(rd_bsel));
    case (op)
      4'd1, 4'd2: if (a < 5 && b < 5) begin
        ba = bk(a);
        bb = (op == 4'd2) ? 1 - bk(b) : bk(b);
        va = m[ba][a];
        vb = m[bb][b];
        m[ba][a] = mg(va, vb);
        m[bb][b] = mg(m[bb][b], va);
      end
      4'd3: if (b >= 1 && b <= 6) begin
        p = (b - 1) / 2;
        hi = (b % 2) == 1;
        t = hi ? m[bk(p)][p][15:8] : m[bk(p)][p][7:0];
        if (hi) m[bk(p)][p][15:8] = ma; else m[bk(p)][p][7:0] = ma;
        ma = t;
      end
      4'd4: if (a >= 1 && a <= 6) begin
        p = (a - 1) / 2;
        if (a % 2) begin
          t = m[0][p][15:8]; m[0][p][15:8] = m[1][p][15:8]; m[1][p][15:8] = t;
        end else begin
          t = m[0][p][7:0];  m[0][p][7:0]  = m[1][p][7:0];  m[1][p][7:0]  = t;
        end
      end
      4'd5: if (a < 5) m[bk(a)][a] = {m[bk(a)][a][15:0], m[bk(a)][a][31:16]};
      4'd6: begin f_pr = ~f_pr; f_ix = ~f_ix; f_iy = ~f_iy; end
      4'd7: f_ix = ~f_ix;
      4'd8: f_iy = ~f_iy;
      4'd0: begin
        if (wr_en && wr_sel < 5)
          m[bk(int'(wr_sel))][wr_sel] = mg(m[bk(int'(wr_sel))][wr_sel], wr_data);
        if (bwr_en) begin
          if (bwr_sel == 0) ma = bwr_data;
          else if (bwr_sel <= 6) begin
            p = (int'(bwr_sel) - 1) / 2;
            if (bwr_sel[0]) m[bk(p)][p][15:8] = bwr_data;
            else            m[bk(p)][p][7:0]  = bwr_data;
          end
        end
      end
      default: ;
    endcase
    es = 32'h0;
    es[8] = f_pr; es[16] = f_ix; es[24] = f_iy;
    @(posedge clk);
    @(negedge clk);
    chk(req, "rd_word", rd_word, ew);
    chk(req, "rd_byte", {24'h0, rd_byte}, {24'h0, eb});
    chk(req, "status", status, es);
  endtask

  task automatic idle();
    op = 4'd0; wr_en = 1'b0; bwr_en = 1'b0;
  endtask

  task automatic wword(input int sel, input logic [31:0] d, input string req);
    idle(); wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d; tick(req); idle();
  endtask

  task automatic wbyte(input int sel, input logic [7:0] d, input string req);
    idle(); bwr_en = 1'b1; bwr_sel = 3'(sel); bwr_data = d; tick(req); idle();
  endtask

  task automatic doop(input int o, input int a, input int b, input string req);
    idle(); op = 4'(o); op_a = 3'(a); op_b = 3'(b); tick(req); idle();
  endtask

  task automatic rd(input int ws, input int bs, input string req);
    idle(); rd_wsel = 3'(ws); rd_bsel = 3'(bs); tick(req);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 5; r++) m[b][r] = 32'h0;
    ma = 8'h0; f_pr = 1'b0; f_ix = 1'b0; f_iy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "rd_word", rd_word, 32'h0);
    chk("R1", "rd_byte", {24'h0, rd_byte}, 32'h0);
    chk("R1", "status", status, 32'h0);
    rd(4, 0, "R1");

    // R3: load primary bank in 32-bit mode
    long_mode = 1'b1;
    for (int r = 0; r < 5; r++) wword(r, 32'hA0A0_0000 + 32'(r) * 32'h0101_1111, "R3");
    wbyte(0, 8'h5A, "R4");
    // R10: flip all, load alternate bank
    doop(6, 0, 0, "R10");
    for (int r = 0; r < 5; r++) wword(r, 32'h5B00_0000 + 32'(r) * 32'h0011_2233, "R3");
    doop(6, 0, 0, "R10");
    // R2: read every code
    for (int r = 0; r < 8; r++) rd(r, r, "R2");
    rd(0, 0, "R2");
    // R3: 16-bit write keeps upper half
    long_mode = 1'b0;
    wword(2, 32'hFFFF_1234, "R3");
    rd(2, 5, "R3");
    // R3: write ignored during an operation
    idle(); op = 4'd1; op_a = 3'd3; op_b = 3'd3; wr_en = 1'b1; wr_sel = 3'd0;
    wr_data = 32'hDEAD_BEEF; bwr_en = 1'b1; bwr_sel = 3'd0; bwr_data = 8'hEE;
    rd_wsel = 3'd0; tick("R3"); idle();
    rd(0, 0, "R3");
    // R4: byte writes and precedence over same-cycle word write
    wbyte(3, 8'hC3, "R4");
    wbyte(6, 8'h6C, "R4");
    rd(1, 3, "R4");
    long_mode = 1'b1;
    idle(); wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h1357_9BDF;
    bwr_en = 1'b1; bwr_sel = 3'd5; bwr_data = 8'h42; tick("R4"); idle();
    rd(2, 5, "R4");
    rd(2, 6, "R4");
    // R5: exchanges of active copies in both modes
    long_mode = 1'b0;
    doop(1, 0, 1, "R5");
    rd(0, 1, "R5"); rd(1, 4, "R5");
    long_mode = 1'b1;
    doop(1, 0, 2, "R5");
    rd(0, 0, "R5"); rd(2, 0, "R5");
    doop(1, 3, 4, "R5");
    rd(3, 0, "R5"); rd(4, 0, "R5");
    // R6: cross-bank exchanges, then view alternate bank
    doop(2, 1, 1, "R6");
    long_mode = 1'b0;
    doop(2, 2, 3, "R6");
    rd(1, 0, "R6"); rd(2, 0, "R6");
    doop(6, 0, 0, "R6");
    rd(1, 0, "R6"); rd(3, 0, "R6");
    doop(6, 0, 0, "R6");
    // R7: A with byte registers
    doop(3, 0, 4, "R7");
    rd(1, 0, "R7"); rd(1, 4, "R7");
    doop(3, 0, 1, "R7");
    rd(0, 1, "R7");
    // R8: byte with alternate copy
    doop(4, 5, 0, "R8");
    rd(2, 5, "R8"); rd(2, 6, "R8");
    doop(6, 0, 0, "R8");
    rd(2, 5, "R8"); rd(2, 6, "R8");
    doop(6, 0, 0, "R8");
    // R9: half swap in 16-bit mode and 32-bit mode
    long_mode = 1'b0;
    doop(5, 4, 0, "R9");
    rd(4, 0, "R9");
    long_mode = 1'b1;
    doop(5, 0, 0, "R9");
    rd(0, 2, "R9");
    // R11: independent index bank flips
    doop(7, 0, 0, "R11");
    rd(3, 0, "R11"); rd(4, 0, "R11"); rd(0, 0, "R11");
    doop(8, 0, 0, "R11");
    rd(4, 0, "R11"); rd(3, 0, "R11");
    doop(7, 0, 0, "R11");
    rd(3, 0, "R11");
    // R12: unused operation codes and register codes
    doop(9, 0, 1, "R12");
    doop(15, 2, 3, "R12");
    doop(1, 6, 0, "R12");
    doop(5, 7, 0, "R12");
    doop(3, 0, 7, "R12");
    rd(0, 0, "R12"); rd(1, 1, "R12");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      idle();
      long_mode = 1'($urandom_range(0, 1));
      op       = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(0, 10));
      op_a     = 3'($urandom_range(0, 7));
      op_b     = 3'($urandom_range(0, 7));
      wr_en    = 1'($urandom_range(0, 1));
      wr_sel   = 3'($urandom_range(0, 7));
      wr_data  = $urandom;
      bwr_en   = 1'($urandom_range(0, 1));
      bwr_sel  = 3'($urandom_range(0, 7));
      bwr_data = 8'($urandom);
      rd_wsel  = 3'($urandom_range(0, 7));
      rd_bsel  = 3'($urandom_range(0, 7));
      tick("mixed");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule